// File: doc/BRIEF.md
# Serial-in latched octal output controller

This block is the logic core of an eight-channel low-side switch that is controlled over a serial link. A host clocks control bits into an eight-stage shift register one bit per rising edge of a serial clock. It then raises a strobe, and the register contents pass into an output buffer. While the strobe is high the buffer follows the register. When the strobe falls, the buffer keeps the last value it showed. Each buffer bit drives one channel-on signal. A 1 turns the channel on.

The last register stage is brought out as a serial output, so several devices can share one serial clock and one strobe in a chain. An active-low enable can switch all eight channels off at once. It does not change the stored data. A power-on reset clears everything.

The serial clock, serial data, strobe and enable are treated as inputs that are synchronous to the system clock. A serial clock edge is detected when the sampled serial clock goes from 0 to 1 between two system clock edges.

Top module: `serial_octal_switch`

## Requirements
- R1: Each 0-to-1 transition of the sampled serial clock shifts exactly one bit into the register, at the first system clock edge where the serial clock is seen high. Holding the serial clock high, or holding it low, shifts nothing further.
- R2: After eight shifts followed by a strobe pulse, the first bit shifted in sets chan_on_o[7] (channel 8) and the last bit shifted in sets chan_on_o[0] (channel 1). A 1 means the channel is on and a 0 means it is off.
- R3: While strobe_i is 1 and en_n_i is 0, chan_on_o shows the current register contents and changes with every shift.
- R4: While strobe_i is 0, chan_on_o keeps the value it showed when the strobe fell, whatever is shifted in meanwhile.
- R5: While en_n_i is 1, chan_on_o is all zeros. The stored buffer value is unchanged, and it appears again when en_n_i returns to 0 with the strobe still low.
- R6: While rst_n is 0, the shift register and the output buffer are cleared, chan_on_o is all zeros and sdo_o is 0.
- R7: sdo_o is the last register stage. After the n-th shift it equals the bit shifted in at shift n-7, so the first bit appears after the eighth shift. While the strobe is high and the block is enabled, sdo_o also equals chan_on_o[7].
- R8: sdo_o changes only at a system clock edge at which a serial clock rise is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| sclk_i | input | 1 | Serial clock, sampled synchronously |
| sdi_i | input | 1 | Serial data in |
| strobe_i | input | 1 | Buffer strobe: the buffer follows the register while this is high and holds when it falls |
| en_n_i | input | 1 | Active-low enable for all channels |
| sdo_o | output | 1 | Serial data out, for chaining further devices |
| chan_on_o | output | WIDTH | Channel-on signals; bit 0 is channel 1 |

## Verification
The case hardest to reach is a strobe that falls at the same clock edge as a serial clock rise. At that edge the held value must be the one already on the outputs, not the bit that has just arrived. The stimulus reaches this case by shifting while the strobe is high and dropping the strobe right after a rise. It then goes on shifting with the strobe low. It also toggles the enable with held data that differs from the register contents. This shows that disabling never disturbs either the held value or the register contents.

// File: rtl/serial_octal_switch.sv
module serial_octal_switch #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_i,
  input  logic             sdi_i,
  input  logic             strobe_i,
  input  logic             en_n_i,
  output logic             sdo_o,
  output logic [WIDTH-1:0] chan_on_o
);
  localparam int LAST = WIDTH - 1;

  logic             sclk_q;
  logic             sclk_rise;
  logic [WIDTH-1:0] shift_q, shift_d, hold_q, view;

  assign sclk_rise = sclk_i & ~sclk_q;
  assign shift_d   = sclk_rise ? {shift_q[LAST-1:0], sdi_i} : shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      shift_q <= '0;
      hold_q  <= '0;
    end else begin
      sclk_q  <= sclk_i;
      shift_q <= shift_d;
      if (strobe_i) hold_q <= shift_d;
    end
  end

  assign view      = strobe_i ? shift_q : hold_q;
  assign chan_on_o = en_n_i ? '0 : view;
  assign sdo_o     = shift_q[LAST];
endmodule

module octal_switch_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sclk_i,
  input logic             strobe_i,
  input logic             en_n_i,
  input logic             sdo_o,
  input logic [WIDTH-1:0] chan_on_o
);
  AST_DISABLED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    en_n_i |-> chan_on_o == '0); // R5
  AST_RESET_OFF: assert property (@(posedge clk)
    !rst_n |-> (chan_on_o == '0 && !sdo_o)); // R6
  AST_SDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(sclk_i) |=> $stable(sdo_o)); // R8
  AST_HOLD_LOW_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_i && !$past(strobe_i) && !en_n_i && !$past(en_n_i)) |-> $stable(chan_on_o)); // R4
  AST_SDO_IS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && !en_n_i) |-> sdo_o == chan_on_o[WIDTH-1]); // R7
endmodule

bind serial_octal_switch octal_switch_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .strobe_i(strobe_i),
  .en_n_i(en_n_i), .sdo_o(sdo_o), .chan_on_o(chan_on_o)
);

// File: tb/sim_serial_octal_switch.sv
`timescale 1ns/1ps
module sim_serial_octal_switch;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdi = 1'b0, stb = 1'b0, en_n = 1'b0;
  logic sdo;
  logic [7:0] chan;

  int checks = 0;
  int errors = 0;

  bit m_sr[$];
  bit m_hold[8];
  bit m_prev;

  always #2 clk = ~clk;

  serial_octal_switch #(.WIDTH(8)) u0 (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdi_i(sdi),
    .strobe_i(stb), .en_n_i(en_n), .sdo_o(sdo), .chan_on_o(chan)
  );

  task automatic model_clear();
    m_sr.delete();
    for (int i = 0; i < 8; i++) begin
      m_sr.push_back(1'b0);
      m_hold[i] = 1'b0;
    end
    m_prev = 1'b0;
  endtask

  function automatic logic [7:0] exp_chan();
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = en_n ? 1'b0 : (stb ? m_sr[i] : m_hold[i]);
    return v;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    if (!rst_n) model_clear();
    else begin
      if (sclk && !m_prev) begin
        m_sr.push_front(sdi);
        void'(m_sr.pop_back());
      end
      m_prev = sclk;
      if (stb) for (int i = 0; i < 8; i++) m_hold[i] = m_sr[i];
    end
    @(negedge clk);
    check(tag, chan, exp_chan(), "chan_on");
    check(tag, {7'd0, sdo}, {7'd0, m_sr[7]}, "sdo");
  endtask

  task automatic shift_bit(bit b, string tag);
    sdi = b; sclk = 1'b1; step(tag);
    sclk = 1'b0; step(tag);
  endtask

  task automatic shift_byte(logic [7:0] v, string tag);
    for (int i = 7; i >= 0; i--) shift_bit(v[i], tag);
  endtask

  initial begin
    #(4 * 5000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) step("R6");
    check("R6", chan, 8'h00, "reset chan_on");
    rst_n = 1'b1;
    step("R6");

    // R7: first bit appears on sdo after eight shifts; strobe low keeps channels off (R4)
    shift_byte(8'hB2, "R7");
    check("R4", chan, 8'h00, "no strobe yet");
    check("R7", {7'd0, sdo}, 8'h01, "first bit at sdo");

    // R2: strobe pulse, channel mapping
    stb = 1'b1; step("R2");
    check("R2", chan, 8'hB2, "after strobe");
    stb = 1'b0; step("R2");
    check("R2", chan, 8'hB2, "held after strobe fall");

    // R3: transparent while strobe high
    stb = 1'b1; step("R3");
    shift_bit(1'b1, "R3");
    check("R3", chan, 8'h65, "transparent one shift");
    shift_bit(1'b0, "R3");
    check("R3", chan, 8'hCA, "transparent two shifts");
    // strobe falls right after a rise
    sdi = 1'b1; sclk = 1'b1; step("R3");
    check("R3", chan, 8'h95, "rise while high");
    stb = 1'b0; step("R4");
    check("R4", chan, 8'h95, "held at fall");
    sclk = 1'b0; step("R4");

    // R4: shifting while strobe low leaves channels unchanged
    shift_byte(8'h0F, "R4");
    check("R4", chan, 8'h95, "held after new byte");

    // R5: disable forces off, data preserved
    en_n = 1'b1; step("R5");
    check("R5", chan, 8'h00, "disabled");
    shift_bit(1'b1, "R5");
    stb = 1'b1; step("R5");
    check("R5", chan, 8'h00, "disabled with strobe");
    stb = 1'b0; step("R5");
    en_n = 1'b0; step("R5");
    check("R5", chan, 8'h1F, "re-enabled shows held");

    // R1 and R8: long high serial clock shifts once
    sdi = 1'b1; sclk = 1'b1;
    repeat (5) step("R8");
    sdi = 1'b0; repeat (3) step("R1");
    sclk = 1'b0; repeat (3) step("R1");
    stb = 1'b1; step("R1");
    check("R1", chan, 8'h3F, "single shift for long high");
    stb = 1'b0; step("R1");

    // R6: reset mid-operation
    rst_n = 1'b0; step("R6");
    check("R6", chan, 8'h00, "mid reset chan_on");
    check("R6", {7'd0, sdo}, 8'h00, "mid reset sdo");
    rst_n = 1'b1; step("R6");
    stb = 1'b1; step("R6");
    check("R6", chan, 8'h00, "register cleared");
    stb = 1'b0; step("R6");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule